// File: doc/BRIEF.md
# GPIO Controller with Change Interrupts

A register-mapped general-purpose I/O block for a parameterised number of pins (at most 32). Software sets each pin's direction, the level it drives when it is an output, and a mask that limits which output bits a data write touches. Each incoming pin level passes through a synchroniser before the block uses it. A register returns the current pin state: the driven level for an output pin and the synchronised level for an input pin.

The block watches every synchronised pin for a level change in either direction. A change sets a sticky per-pin flag, and software clears a flag by writing a one to it. One interrupt line is high while any flagged pin is also enabled. Only both-edge detection exists. A read-only type register reports this, with a 1 for every implemented pin.

The bus has no handshake. Each write completes in one cycle, and read data is a combinational function of the address and the register state. Word offsets: 0x00 direction, 0x04 data, 0x08 interrupt enable, 0x0C change flags, 0x10 data write mask, 0x14 interrupt type. Address bits [1:0] are ignored.

Top module: `gpio_ctrl`

## Requirements
- R1: Reset state. After reset every pin is an input (`pin_oe` = 0), `pin_out` = 0, all enables are 0, all change flags are 0, the write mask reads all ones over the pin bits, and `irq` = 0.
- R2: Direction register at offset 0x00. A bit of 1 makes that pin an output and a bit of 0 makes it an input. `pin_oe` shows the register contents in the cycle after the write.
- R3: Data register at offset 0x04. Reads return the output register value for output pins and the synchronised input for input pins. A change on `pin_in` reaches this read after SYNC_STAGES clock edges.
- R4: Write-mask register at offset 0x10. A write to the data register changes only the output bits whose mask bit is 1. Bits whose mask bit is 0 keep their value.
- R5: Change register at offset 0x0C. A bit is set on both rising and falling changes of its synchronised pin. The bit becomes visible SYNC_STAGES+1 clock edges after the change on `pin_in`. Once set, it stays set until cleared.
- R6: A bit of the change register clears when a 1 is written to it. Writing 0 leaves the bit unchanged. If a new edge on that pin arrives in the same cycle as the clearing write, the bit stays set.
- R7: Interrupt-enable register at offset 0x08, where 1 means enabled. `irq` is 1 exactly when the bitwise AND of the change register and the enable register is nonzero. `irq` follows register changes with no added cycle.
- R8: Type register at offset 0x14. It reads a 1 in every implemented pin bit, which is the code for both-edge mode. Writes to it have no effect.
- R9: Register bits at and above NPINS read 0. Offsets 0x18 and 0x1C read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Pad input levels, asynchronous |
| pin_out | output | NPINS | Output levels driven to the pads |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Combined change interrupt |

## Verification
A wrong synchroniser depth or a wrong edge-detection register shows up in two ways. Data reads of input pins move on the wrong edge, and change flags appear one cycle early or late, or are missing on one edge direction. Either shows within SYNC_STAGES+1 cycles of a pin change. A wrong change flag or enable bit reaches `irq` in the same cycle, so the per-clock comparison of `irq`, `pin_out`, `pin_oe` and the read data catches it on the first clock where the model disagrees. The test times a clearing write to land in the same cycle as a fresh edge, which exposes the priority between those two updates.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    localparam int BUS_W    = 32;
    localparam int WORD_LSB = 2;
    localparam int SEL_W    = 3;
    localparam int SEL_MSB  = WORD_LSB + SEL_W - 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIR   = 3'd0,
        SEL_DATA  = 3'd1,
        SEL_IEN   = 3'd2,
        SEL_CHG   = 3'd3,
        SEL_WMASK = 3'd4,
        SEL_TYPE  = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/gpio_insync.sv
module gpio_insync #(
    parameter int N      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] edge_hit
);

    logic [STAGES-1:0][N-1:0] stage_q;
    logic [N-1:0]             prev_q;

    // synchroniser chain; stage 0 samples the pad
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            prev_q  <= '0;
        end else begin
            for (int k = STAGES - 1; k > 0; k--) begin
                stage_q[k] <= stage_q[k-1];
            end
            stage_q[0] <= pin_raw;
            prev_q     <= stage_q[STAGES-1];
        end
    end

    assign lvl      = stage_q[STAGES-1];
    assign edge_hit = stage_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_ctrl_pkg::*;
#(
    parameter int N      = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [N-1:0]      wd,
    input  logic [N-1:0]      lvl,
    input  logic [N-1:0]      edge_hit,
    output logic [N-1:0]      dir,
    output logic [N-1:0]      dout,
    output logic [N-1:0]      ien,
    output logic [N-1:0]      chg,
    output logic [N-1:0]      wmask,
    output logic [N-1:0]      rd
);

    localparam logic [N-1:0] PIN_ONES = {N{1'b1}};

    logic     hi_zero;
    reg_sel_e sel;
    logic     wr_dir, wr_data, wr_ien, wr_chg, wr_wmask;
    logic [N-1:0] dir_q, out_q, ien_q, chg_q, wmask_q;

    generate
        if (ADDR_W > SEL_MSB + 1) begin : g_hi
            assign hi_zero = (addr[ADDR_W-1:SEL_MSB+1] == '0);
        end else begin : g_nohi
            assign hi_zero = 1'b1;
        end
    endgenerate

    logic unused_lo;
    assign unused_lo = ^addr[WORD_LSB-1:0];

    assign sel      = reg_sel_e'(addr[SEL_MSB:WORD_LSB]);
    assign wr_dir   = we && hi_zero && (sel == SEL_DIR);
    assign wr_data  = we && hi_zero && (sel == SEL_DATA);
    assign wr_ien   = we && hi_zero && (sel == SEL_IEN);
    assign wr_chg   = we && hi_zero && (sel == SEL_CHG);
    assign wr_wmask = we && hi_zero && (sel == SEL_WMASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            out_q   <= '0;
            ien_q   <= '0;
            chg_q   <= '0;
            wmask_q <= PIN_ONES;
        end else begin
            if (wr_dir)   dir_q   <= wd;
            if (wr_data)  out_q   <= (out_q & ~wmask_q) | (wd & wmask_q);
            if (wr_ien)   ien_q   <= wd;
            if (wr_wmask) wmask_q <= wd;
            // new edges win over a same-cycle clear
            chg_q <= (chg_q & ~(wr_chg ? wd : '0)) | edge_hit;
        end
    end

    always_comb begin
        rd = '0;
        if (hi_zero) begin
            unique case (sel)
                SEL_DIR:   rd = dir_q;
                SEL_DATA:  rd = (dir_q & out_q) | (~dir_q & lvl);
                SEL_IEN:   rd = ien_q;
                SEL_CHG:   rd = chg_q;
                SEL_WMASK: rd = wmask_q;
                SEL_TYPE:  rd = PIN_ONES;
                default:   rd = '0;
            endcase
        end
    end

    assign dir   = dir_q;
    assign dout  = out_q;
    assign ien   = ien_q;
    assign chg   = chg_q;
    assign wmask = wmask_q;

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
    parameter int N = 16
) (
    input  logic [N-1:0] chg,
    input  logic [N-1:0] ien,
    output logic         irq
);

    logic [N-1:0] pend;

    generate
        for (genvar g = 0; g < N; g++) begin : g_pin
            assign pend[g] = chg[g] & ien[g];
        end
    endgenerate

    assign irq = |pend;

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);

    logic [NPINS-1:0] wd_pins, lvl_w, edge_w, ien_w, chg_w, wmask_w, rd_w;

    assign wd_pins = bus_wdata[NPINS-1:0];

    generate
        if (NPINS < BUS_W) begin : g_pad
            logic unused_hi;
            assign unused_hi = ^bus_wdata[BUS_W-1:NPINS];
        end
    endgenerate

    gpio_insync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .lvl      (lvl_w),
        .edge_hit (edge_w)
    );

    gpio_regfile #(.N(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .wd       (wd_pins),
        .lvl      (lvl_w),
        .edge_hit (edge_w),
        .dir      (pin_oe),
        .dout     (pin_out),
        .ien      (ien_w),
        .chg      (chg_w),
        .wmask    (wmask_w),
        .rd       (rd_w)
    );

    gpio_irq_merge #(.N(NPINS)) u_irq (
        .chg (chg_w),
        .ien (ien_w),
        .irq (irq)
    );

    assign bus_rdata = BUS_W'(rd_w);

endmodule

module gpio_ctrl_chk #(
    parameter int N      = 16,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [N-1:0]      wd,
    input logic [N-1:0]      oe,
    input logic [N-1:0]      dout,
    input logic [N-1:0]      wmask,
    input logic [N-1:0]      chg,
    input logic [N-1:0]      ien,
    input logic [N-1:0]      edge_hit,
    input logic              irq
);

    logic hit_dir, hit_data, hit_chg;
    assign hit_dir  = we && (addr[ADDR_W-1:2] == (ADDR_W-2)'(0));
    assign hit_data = we && (addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
    assign hit_chg  = we && (addr[ADDR_W-1:2] == (ADDR_W-2)'(3));

    // R2: output enables move only on a direction write
    a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_dir |=> $stable(oe));

    // R4: masked-off output bits survive a data write
    a_r4_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
        hit_data |=> (((dout ^ $past(dout)) & ~$past(wmask)) == '0));

    // R5: every detected edge leaves its flag set
    a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((chg & $past(edge_hit)) == $past(edge_hit)));

    // R6: written ones clear unless a fresh edge coincides
    a_r6_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
        hit_chg |=> ((chg & $past(wd) & ~$past(edge_hit)) == '0));

    // R5/R6: flags hold with no edge and no clearing write
    a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_chg && edge_hit == '0) |=> $stable(chg));

    // R7: interrupt line agrees with enabled flags
    a_r7_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((chg & ien) != '0));

endmodule

bind gpio_ctrl gpio_ctrl_chk #(.N(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (bus_we),
    .addr     (bus_addr),
    .wd       (wd_pins),
    .oe       (pin_oe),
    .dout     (pin_out),
    .wmask    (wmask_w),
    .chg      (chg_w),
    .ien      (ien_w),
    .edge_hit (edge_w),
    .irq      (irq)
);

// File: tb/sim_gpio_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_ctrl;

    localparam int N  = 16;
    localparam int AW = 5;
    localparam int S  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    gpio_ctrl #(.NPINS(N), .ADDR_W(AW), .SYNC_STAGES(S)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // behavioural reference
    logic [N-1:0] m_dir, m_out, m_ien, m_chg, m_wm;
    logic [N-1:0] hist[$];

    task automatic model_reset();
        m_dir = '0; m_out = '0; m_ien = '0; m_chg = '0; m_wm = '1;
        hist.delete();
        for (int k = 0; k <= S; k++) hist.push_back('0);
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            logic [N-1:0] ev;
            logic [N-1:0] clr;
            int idx;
            ev  = hist[S-1] ^ hist[S];
            idx = int'(bus_addr) / 4;
            clr = '0;
            if (bus_we) begin
                case (idx)
                    0: m_dir = bus_wdata[N-1:0];
                    1: m_out = (m_out & ~m_wm) | (bus_wdata[N-1:0] & m_wm);
                    2: m_ien = bus_wdata[N-1:0];
                    3: clr   = bus_wdata[N-1:0];
                    4: m_wm  = bus_wdata[N-1:0];
                    default: ;
                endcase
            end
            m_chg = (m_chg & ~clr) | ev;
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
    end

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        logic [N-1:0] v;
        case (int'(a) / 4)
            0: v = m_dir;
            1: v = (m_dir & m_out) | (~m_dir & hist[S-1]);
            2: v = m_ien;
            3: v = m_chg;
            4: v = m_wm;
            5: v = '1;
            default: v = '0;
        endcase
        return 32'(v);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // per-clock comparison against the model (R2 R3 R4 R7 R9)
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            check("R2 pin_oe vs model", 32'(pin_oe), 32'(m_dir));
            check("R4 pin_out vs model", 32'(pin_out), 32'(m_out));
            check("R7 irq vs model", 32'(irq), 32'((m_chg & m_ien) != '0));
            check("R9 rdata vs model", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(5'h00, 32'h0, "R1 dir after reset");
        rd(5'h04, 32'h0, "R1 data after reset");
        rd(5'h08, 32'h0, "R1 ien after reset");
        rd(5'h0C, 32'h0, "R1 chg after reset");
        rd(5'h10, 32'h0000FFFF, "R1 wmask after reset");
        check("R1 irq after reset", 32'(irq), 32'h0);
        check("R1 pin_oe after reset", 32'(pin_oe), 32'h0);

        // R2 direction
        wr(5'h00, 32'h0000_00FF);
        check("R2 pin_oe after write", 32'(pin_oe), 32'h00FF);
        rd(5'h00, 32'h00FF, "R2 dir readback");

        // R3 data: outputs from register, inputs from pins
        wr(5'h04, 32'h0000_1234);
        check("R3 pin_out", 32'(pin_out), 32'h1234);
        rd(5'h04, 32'h0034, "R3 data read, inputs low");
        @(negedge clk); pin_in = 16'hA500;
        idle(S);
        rd(5'h04, 32'hA534, "R3 data read after sync");

        // R5 rising edges flagged
        idle(2);
        rd(5'h0C, 32'hA500, "R5 chg after rising edges");
        check("R7 irq disabled", 32'(irq), 32'h0);

        // R7 enable, R6 clear
        wr(5'h08, 32'h0000_0100);
        check("R7 irq enabled", 32'(irq), 32'h1);
        wr(5'h0C, 32'h0000_0100);
        check("R6 irq after clear", 32'(irq), 32'h0);
        rd(5'h0C, 32'hA400, "R6 chg after w1c");
        wr(5'h0C, 32'h0000_0000);
        rd(5'h0C, 32'hA400, "R6 zero write keeps flags");

        // R5 falling edge
        wr(5'h0C, 32'h0000_FFFF);
        rd(5'h0C, 32'h0, "R6 clear all");
        @(negedge clk); pin_in = 16'h2500;
        idle(S + 2);
        rd(5'h0C, 32'h8000, "R5 chg after falling edge");

        // R6 edge coinciding with clear keeps the bit
        wr(5'h0C, 32'h0000_FFFF);
        @(negedge clk); pin_in = pin_in ^ 16'h0002;
        @(negedge clk);
        wr(5'h0C, 32'h0000_0002);
        rd(5'h0C, 32'h0002, "R6 edge wins over clear");

        // R4 write mask
        wr(5'h10, 32'h0000_00F0);
        rd(5'h10, 32'h00F0, "R4 wmask readback");
        wr(5'h04, 32'h0000_FFFF);
        check("R4 masked data write", 32'(pin_out), 32'h12F4);
        wr(5'h10, 32'h0000_FFFF);
        wr(5'h04, 32'h0000_0000);
        check("R4 full mask write", 32'(pin_out), 32'h0);

        // R8 type register
        rd(5'h14, 32'h0000FFFF, "R8 type read");
        wr(5'h14, 32'h0000_0000);
        rd(5'h14, 32'h0000FFFF, "R8 type write ignored");

        // R9 upper bits and unmapped offsets
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, 32'h0000FFFF, "R9 upper dir bits zero");
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, 32'h0, "R9 offset 0x18 reads zero");
        rd(5'h1C, 32'h0, "R9 offset 0x1C reads zero");
        check("R9 unmapped write no effect", 32'(pin_out), 32'h0);

        idle(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule